// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Selector

This block keeps one pending flag for each of thirteen interrupt sources and, whenever the core offers a delivery opportunity, names at most one of them to be taken. Sources are raised by single-cycle set strobes. A flag then stays pending until a delivery clears it, and some sources never clear on delivery.

Each source is qualified by the current processor state: external enable, critical enable and hypervisor mode. Two control bits also take part, one for the hypervisor decrementer and one for partition-routed externals, together with a flag saying whether hypervisor mode exists at all. Among the qualified sources a fixed priority picks the winner.

The chosen source appears as a 4-bit code with a one-cycle valid pulse. A separate output shows whether any request remains, and the core uses it to decide whether to keep its interrupt request raised. Saving state and jumping to a handler are done elsewhere.

Top module: `irqsel_top`

## Requirements
- R1: After reset no flag is pending, `valid_o` is 0, `code_o` is 0 and `any_pending_o` is 0.
- R2: Codes, highest priority first, are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. `set_i[k]` raises the source with code k. The qualified pending source with the lowest code is the one delivered.
- R3: Reset (0) and machine check (1) qualify whatever the gating inputs are, and their flags clear when they are delivered.
- R4: The hypervisor decrementer (2) qualifies only when `hdec_en_i`=1 and either `ext_en_i`=1 or `hv_mode_i`=0. Its flag clears on delivery.
- R5: External (3) qualifies when `ext_en_i`=1, or when `hv_present_i`=1, `hv_mode_i`=0 and `part_ext_i`=0. Delivery leaves its flag set.
- R6: Critical external (4) qualifies only when `crit_en_i`=1. Delivery leaves its flag set.
- R7: Sources 5, 6, 7, 8, 10, 11 and 12 qualify only when `ext_en_i`=1, and their flags clear on delivery.
- R8: The decrementer (9) qualifies only when `ext_en_i`=1. Its flag clears on delivery only when `dec_clr_i`=1 in the delivery cycle.
- R9: If `take_i`=1 in a cycle and some source qualifies, `valid_o`=1 with `code_o` set to the winner's code in the following cycle. Otherwise `valid_o`=0 and `code_o`=0. At most one source is delivered per opportunity.
- R10: `any_pending_o` is 1 exactly when at least one flag is set, and it reflects every set and clear of the previous cycle.
- R11: When a set strobe and a delivery clear hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 13 | Per-source set strobes, bit k = code k |
| ext_en_i | input | 1 | External interrupt enable state bit |
| crit_en_i | input | 1 | Critical interrupt enable state bit |
| hv_mode_i | input | 1 | Core is running in hypervisor mode |
| hv_present_i | input | 1 | Hypervisor mode is implemented |
| hdec_en_i | input | 1 | Hypervisor decrementer delivery enable control |
| part_ext_i | input | 1 | Partition external control (0 routes externals to hypervisor regardless of enable) |
| dec_clr_i | input | 1 | Decrementer clears on delivery |
| take_i | input | 1 | Delivery opportunity strobe |
| valid_o | output | 1 | One-cycle pulse: a source was delivered |
| code_o | output | 4 | Code of the delivered source |
| any_pending_o | output | 1 | At least one request remains pending |

## Verification
The bench sweeps every source alone against all 64 combinations of the six gating bits, under both decrementer clear settings. A mistaken gate would then either deliver a source that should be masked or stay silent when it should fire. Level sources are checked to remain pending after delivery; a design that cleared them would drop `any_pending_o` too early. A full drain checks the priority order and shows that a sticky external keeps blocking every source below it. A take on the same cycle as a new set of that source must leave it pending; a design that let the clear win would lose the request.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int unsigned NSRC   = 13;
  localparam int unsigned CODE_W = $clog2(NSRC);

  typedef enum logic [CODE_W-1:0] {
    SRC_RST    = 4'd0,
    SRC_MCHK   = 4'd1,
    SRC_HDEC   = 4'd2,
    SRC_EXT    = 4'd3,
    SRC_CEXT   = 4'd4,
    SRC_WDOG   = 4'd5,
    SRC_CDBELL = 4'd6,
    SRC_FIT    = 4'd7,
    SRC_PIT    = 4'd8,
    SRC_DEC    = 4'd9,
    SRC_DBELL  = 4'd10,
    SRC_PERF   = 4'd11,
    SRC_THERM  = 4'd12
  } src_e;

  typedef struct packed {
    logic ext_en;
    logic crit_en;
    logic hv_mode;
    logic hv_present;
    logic hdec_en;
    logic part_ext;
  } gate_t;

  // Which sources the current state lets through (R3..R8)
  function automatic logic [NSRC-1:0] gate_mask(input gate_t g);
    logic [NSRC-1:0] m;
    m = '0;
    m[SRC_RST]  = 1'b1;
    m[SRC_MCHK] = 1'b1;
    m[SRC_HDEC] = g.hdec_en & (g.ext_en | ~g.hv_mode);
    m[SRC_EXT]  = g.ext_en | (g.hv_present & ~g.hv_mode & ~g.part_ext);
    m[SRC_CEXT] = g.crit_en;
    for (int i = int'(SRC_WDOG); i < int'(NSRC); i++) m[i] = g.ext_en;
    return m;
  endfunction

  // Which sources drop their flag when delivered
  function automatic logic [NSRC-1:0] take_clear_mask(input logic dec_clr);
    logic [NSRC-1:0] m;
    m = '1;
    m[SRC_EXT]  = 1'b0;
    m[SRC_CEXT] = 1'b0;
    m[SRC_DEC]  = dec_clr;
    return m;
  endfunction
endpackage

// File: rtl/irqsel_pending_bank.sv
module irqsel_pending_bank #(
  parameter int unsigned N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (set_i[k])   flag_q <= 1'b1;   // set beats clear
      else if (clr_i[k])   flag_q <= 1'b0;
    end
    assign pend_o[k] = flag_q;
  end

  // R11: a strobe in the previous cycle always leaves the flag set
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(set_i) & ~pend_o) == '0));
endmodule

// File: rtl/irqsel_qualify.sv
module irqsel_qualify
  import irqsel_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  gate_t           gate_i,
  output logic [NSRC-1:0] elig_o
);
  assign elig_o = pend_i & gate_mask(gate_i);
endmodule

// File: rtl/irqsel_prio_pick.sv
module irqsel_prio_pick #(
  parameter int unsigned N = 13,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic [W-1:0] idx_o,
  output logic         hit_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end
  assign hit_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
  import irqsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   set_i,
  input  logic              ext_en_i,
  input  logic              crit_en_i,
  input  logic              hv_mode_i,
  input  logic              hv_present_i,
  input  logic              hdec_en_i,
  input  logic              part_ext_i,
  input  logic              dec_clr_i,
  input  logic              take_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o,
  output logic              any_pending_o
);
  gate_t             gate;
  logic [NSRC-1:0]   pend;
  logic [NSRC-1:0]   elig;
  logic [NSRC-1:0]   grant;
  logic [NSRC-1:0]   deliver_clr;
  logic [CODE_W-1:0] win_idx;
  logic              win_hit;
  logic              fire;
  logic              valid_q;
  logic [CODE_W-1:0] code_q;

  assign gate = '{ext_en: ext_en_i, crit_en: crit_en_i, hv_mode: hv_mode_i,
                  hv_present: hv_present_i, hdec_en: hdec_en_i,
                  part_ext: part_ext_i};

  irqsel_pending_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(deliver_clr), .pend_o(pend)
  );

  irqsel_qualify u_qual (.pend_i(pend), .gate_i(gate), .elig_o(elig));

  irqsel_prio_pick #(.N(NSRC)) u_pick (
    .req_i(elig), .grant_o(grant), .idx_o(win_idx), .hit_o(win_hit)
  );

  assign fire        = take_i & win_hit;
  assign deliver_clr = fire ? (grant & take_clear_mask(dec_clr_i)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= fire;
      code_q  <= fire ? win_idx : '0;
    end
  end

  assign valid_o       = valid_q;
  assign code_o        = code_q;
  assign any_pending_o = |pend;

  // R9: a pulse only follows an offered opportunity
  assert_valid_needs_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(take_i));
  // R9: the picker never grants two sources
  assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R5: external is a level request, never cleared by delivery
  assert_ext_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pend[SRC_EXT]));
  // R6: critical external is a level request as well
  assert_cext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pend[SRC_CEXT]));
  // R7: with external enable low, none of the low group qualifies
  assert_low_group_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en_i |-> (elig[NSRC-1:SRC_WDOG] == '0));
endmodule

// File: tb/tb_irqsel_top.sv
module tb_irqsel_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] set_i = '0;
  logic ext_en_i = 0, crit_en_i = 0, hv_mode_i = 0, hv_present_i = 0;
  logic hdec_en_i = 0, part_ext_i = 0, dec_clr_i = 0, take_i = 0;
  logic valid_o;
  logic [3:0] code_o;
  logic any_pending_o;

  int errors = 0;
  int checks = 0;
  logic [NS-1:0] m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqsel_top dut (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .ext_en_i(ext_en_i),
    .crit_en_i(crit_en_i), .hv_mode_i(hv_mode_i), .hv_present_i(hv_present_i),
    .hdec_en_i(hdec_en_i), .part_ext_i(part_ext_i), .dec_clr_i(dec_clr_i),
    .take_i(take_i), .valid_o(valid_o), .code_o(code_o),
    .any_pending_o(any_pending_o)
  );

  function automatic bit allowed(int s);
    case (s)
      0, 1:    return 1'b1;
      2:       return hdec_en_i && (ext_en_i || !hv_mode_i);
      3:       return ext_en_i || (hv_present_i && !hv_mode_i && !part_ext_i);
      4:       return crit_en_i;
      default: return ext_en_i;
    endcase
  endfunction

  function automatic bit drops_on_take(int s);
    if (s == 3 || s == 4) return 1'b0;
    if (s == 9) return dec_clr_i;
    return 1'b1;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0, 1:    return "R3";
      2:       return "R4";
      3:       return "R5";
      4:       return "R6";
      9:       return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, check outputs at the next falling edge
  task automatic step(input logic [NS-1:0] s, input bit tk, input string rq);
    int win = -1;
    set_i  = s;
    take_i = tk;
    if (tk) begin
      for (int i = NS - 1; i >= 0; i--)
        if (m_pend[i] && allowed(i)) win = i;
    end
    if (win >= 0 && drops_on_take(win)) m_pend[win] = 1'b0;
    m_pend = m_pend | s;
    @(negedge clk);
    check(rq, "valid", int'(valid_o), (win >= 0) ? 1 : 0);
    check(rq, "code", int'(code_o), (win >= 0) ? win : 0);
    check("R10", "any_pending", int'(any_pending_o), (m_pend != '0) ? 1 : 0);
    set_i  = '0;
    take_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_i = '0;
    take_i = 1'b0;
    m_pend = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_gates(int g, bit dc);
    {ext_en_i, crit_en_i, hv_mode_i, hv_present_i, hdec_en_i, part_ext_i} = 6'(g);
    dec_clr_i = dc;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", "valid", int'(valid_o), 0);
    check("R1", "code", int'(code_o), 0);
    check("R1", "any_pending", int'(any_pending_o), 0);

    // Exhaustive single-source sweep over all gating combos
    for (int src = 0; src < NS; src++) begin
      for (int g = 0; g < 64; g++) begin
        for (int dc = 0; dc < 2; dc++) begin
          do_reset();
          set_gates(g, dc[0]);
          step(NS'(1) << src, 1'b0, "R9");   // set alone, no pulse
          step('0, 1'b1, tag_of(src));       // opportunity
          step('0, 1'b0, "R9");              // pulse lasts one cycle
        end
      end
    end

    // R2 priority drain, level sources left out
    do_reset();
    set_gates(6'b110010, 1'b1);
    step(~(NS'(1) << 3 | NS'(1) << 4), 1'b0, "R2");
    for (int n = 0; n < 12; n++) step('0, 1'b1, "R2");
    step('0, 1'b1, "R9");                    // nothing left: no pulse

    // R5 sticky external blocks everything below it
    do_reset();
    set_gates(6'b100000, 1'b1);
    step('1, 1'b0, "R2");
    for (int n = 0; n < 6; n++) step('0, 1'b1, "R5");

    // R11 set and delivery-clear in the same cycle
    do_reset();
    set_gates(6'b100000, 1'b1);
    step(NS'(1) << 7, 1'b0, "R11");
    step(NS'(1) << 7, 1'b1, "R11");
    step('0, 1'b1, "R11");
    step('0, 1'b1, "R11");

    // R8 decrementer kept when clear-on-take is off, then cleared
    do_reset();
    set_gates(6'b100000, 1'b0);
    step(NS'(1) << 9, 1'b0, "R8");
    step('0, 1'b1, "R8");
    step('0, 1'b1, "R8");
    dec_clr_i = 1'b1;
    step('0, 1'b1, "R8");
    step('0, 1'b1, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule